// File: doc/BRIEF.md
# AES byte-substitution and row-rotation stage

This stage performs two of the four AES round operations on a full 128-bit state: it swaps every byte through the AES substitution box and rotates the rows of the 4x4 state matrix. One mode input picks the direction. With encryption selected, the stage applies the forward box and then rotates the rows toward lower column indices. With decryption selected, it rotates the rows toward higher column indices and then applies the inverse box.

The substitution is not a stored 256-entry table. Each byte goes through logic that computes the multiplicative inverse in GF(2^8) and an affine map. For the forward box the affine map comes after the inversion; for the inverse box the inverse affine map comes before it. The 16 byte lanes each have one inverter, and both directions share it.

Input and output use a valid/ready handshake. The result is registered and leaves one cycle after the input is accepted. A held result stalls new input until the consumer takes it. Column mixing and round-key addition belong to neighbouring stages.

Top module: `aes_subrot`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1 until an input is accepted.
- R2: Forward substitution is the GF(2^8) multiplicative inverse modulo x^8+x^4+x^3+x+1 (0 maps to 0), followed by the affine map with constant 0x63. Examples: 0x00 becomes 0x63 and 0x69 becomes 0xF9. The upper nibble of a byte is its table row and the lower nibble its column.
- R3: Inverse substitution applies the inverse affine map (constant 0x05) and then the GF(2^8) inversion. It undoes R2 exactly, so 0x63 becomes 0x00, and decrypting an encrypted result gives back the original state.
- R4: State byte k sits at bits [127-8k -: 8], in row k mod 4 and column k/4. In encryption mode the output at (row r, column c) is the forward substitution of the input at (r, (c+r) mod 4), so row 0 is not moved.
- R5: In decryption mode the output at (r, c) is the inverse substitution of the input at (r, (c-r) mod 4). The rotation runs opposite to R4.
- R6: `in_decrypt` = 1 selects decryption and 0 selects encryption. It is sampled together with the data when an input is accepted, and every transfer may use a different mode.
- R7: An input is accepted on a rising edge where `in_valid` and `in_ready` are both 1. On the next edge `out_valid` is 1 and `out_state` holds the result.
- R8: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is 1 and `out_ready` is 0, `out_state` and `out_valid` hold and no input is accepted.
- R9: When the output is consumed and no new input is accepted on the same edge, `out_valid` goes to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input state is offered |
| in_ready | output | 1 | Stage can accept an input this cycle |
| in_decrypt | input | 1 | 1 = decryption, 0 = encryption |
| in_state | input | 128 | Input state, byte 0 in bits 127:120 |
| out_valid | output | 1 | Registered result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_state | output | 128 | Result state, same byte order as the input |

## Verification
The bench checks the all-zero state in encryption mode and the all-0x63 state in decryption mode. An inverter that treats zero wrongly, or a wrong affine constant, would show up there as bytes other than 0x63 or 0x00. It places 0x69 in the unrotated row to check one known box entry, and it runs a state through encryption and then decryption. A rotation in the wrong direction, or a wrong choice of which rows to rotate, would fail to return the original bytes. Random back-pressure with random mode changes checks that a stalled result holds. A design that overwrote a held result, or lost a transfer, would report the wrong data or a wrong `out_valid`.

// File: rtl/aes_subrot.sv
module aes_subrot #(
  parameter int NBYTES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic                 in_decrypt,
  input  logic [8*NBYTES-1:0]  in_state,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [8*NBYTES-1:0]  out_state
);
  localparam int W    = 8 * NBYTES;
  localparam int ROWS = 4;
  localparam int COLS = NBYTES / ROWS;

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) p = p ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] sq, acc;
    sq  = a;
    acc = 8'h01;
    for (int k = 0; k < 7; k++) begin
      sq  = gmul(sq, sq);
      acc = gmul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] aff_fwd(input logic [7:0] a);
    return a ^ {a[6:0], a[7]} ^ {a[5:0], a[7:6]} ^ {a[4:0], a[7:5]}
             ^ {a[3:0], a[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] aff_inv(input logic [7:0] s);
    return {s[6:0], s[7]} ^ {s[4:0], s[7:5]} ^ {s[1:0], s[7:2]} ^ 8'h05;
  endfunction

  logic [W-1:0] lane_out;
  logic [W-1:0] next_state;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    localparam int R   = i % ROWS;
    localparam int C   = i / ROWS;
    localparam int SRC = ((C + COLS - R) % COLS) * ROWS + R;
    logic [7:0] pre, inv;
    assign pre = in_decrypt ? aff_inv(in_state[W-1-8*SRC -: 8]) : in_state[W-1-8*i -: 8];
    assign inv = ginv(pre);
    assign lane_out[W-1-8*i -: 8] = in_decrypt ? inv : aff_fwd(inv);
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_rot
    localparam int R   = i % ROWS;
    localparam int C   = i / ROWS;
    localparam int SRC = ((C + R) % COLS) * ROWS + R;
    assign next_state[W-1-8*i -: 8] = in_decrypt ? lane_out[W-1-8*i -: 8]
                                                 : lane_out[W-1-8*SRC -: 8];
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_state <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_state <= next_state;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

module aes_subrot_chk #(
  parameter int NBYTES = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                in_decrypt,
  input logic [8*NBYTES-1:0] in_state,
  input logic                out_valid,
  input logic                out_ready,
  input logic [8*NBYTES-1:0] out_state
);
  a_r7_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r8_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_state));

  a_r8_no_accept_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r9_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r2_zero_to_63: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_decrypt && in_state == '0 |=> out_state == {NBYTES{8'h63}});

  a_r3_63_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_decrypt && in_state == {NBYTES{8'h63}} |=> out_state == '0);
endmodule

bind aes_subrot aes_subrot_chk #(.NBYTES(NBYTES)) u_chk (.*);

// File: tb/test_aes_subrot.sv
`timescale 1ns/1ps
module test_aes_subrot;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_decrypt = 1'b0, out_ready = 1'b1;
  logic [127:0] in_state = '0;
  logic in_ready, out_valid;
  logic [127:0] out_state;

  aes_subrot i_aes_subrot (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] fwd [256];
  logic [7:0] inv [256];
  logic exp_v = 1'b0;
  logic [127:0] exp_s = '0;
  string exp_tag = "";

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  task automatic build_boxes();
    logic [7:0] p, q, x;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      fwd[p] = x ^ 8'h63;
    end while (p != 8'h01);
    fwd[0] = 8'h63;
    for (int k = 0; k < 256; k++) inv[fwd[k]] = k[7:0];
  endtask

  function automatic logic [127:0] model(input logic [127:0] d, input logic dec);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) begin
      int r, c, s;
      r = i % 4; c = i / 4;
      if (!dec) begin
        s = ((c + r) % 4) * 4 + r;
        o[127-8*i -: 8] = fwd[d[127-8*s -: 8]];
      end else begin
        s = ((c + 4 - r) % 4) * 4 + r;
        o[127-8*i -: 8] = inv[d[127-8*s -: 8]];
      end
    end
    return o;
  endfunction

  task automatic step(input logic iv, input logic [127:0] d, input logic dec, input logic ordy);
    @(negedge clk);
    chk("R7 R9 out_valid", {127'd0, out_valid}, {127'd0, exp_v});
    if (exp_v) chk(exp_tag, out_state, exp_s);
    in_valid = iv; in_state = d; in_decrypt = dec; out_ready = ordy;
    #1;
    chk("R8 in_ready", {127'd0, in_ready}, {127'd0, (!exp_v || ordy)});
    if (iv && (!exp_v || ordy)) begin
      exp_s = model(d, dec);
      exp_v = 1'b1;
      exp_tag = dec ? "R3 R5 R6 dec data" : "R2 R4 R6 enc data";
    end else if (ordy) begin
      exp_v = 1'b0;
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] a, b, y;
    void'($urandom(32'd7));
    build_boxes();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out_valid", {127'd0, out_valid}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle out_valid", {127'd0, out_valid}, 128'd0);
    chk("R1 idle in_ready", {127'd0, in_ready}, 128'd1);

    step(1'b1, '0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0);
    chk("R2 zero maps to 63", out_state, {16{8'h63}});
    step(1'b0, '0, 1'b0, 1'b1);

    a = 128'h69000000_00000000_00000000_00000000;
    step(1'b1, a, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0);
    chk("R2 R4 0x69 to 0xF9 row0", {120'd0, out_state[127:120]}, 128'hF9);
    step(1'b0, '0, 1'b0, 1'b1);

    step(1'b1, {16{8'h63}}, 1'b1, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0);
    chk("R3 63 maps to zero", out_state, '0);
    step(1'b0, '0, 1'b0, 1'b1);

    a = 128'h00112233_44556677_8899AABB_CCDDEEFF;
    step(1'b1, a, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0);
    y = out_state;
    step(1'b1, y, 1'b1, 1'b1);
    step(1'b0, '0, 1'b0, 1'b0);
    chk("R3 R4 R5 round trip", out_state, a);
    step(1'b0, '0, 1'b0, 1'b1);

    a = {$urandom, $urandom, $urandom, $urandom};
    b = {$urandom, $urandom, $urandom, $urandom};
    step(1'b1, a, 1'b0, 1'b0);
    step(1'b1, b, 1'b1, 1'b0);
    step(1'b1, b, 1'b1, 1'b0);
    step(1'b0, '0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b1);

    for (int n = 0; n < 600; n++) begin
      logic [127:0] d;
      d = {$urandom, $urandom, $urandom, $urandom};
      step(($urandom % 4) != 0, d, $urandom % 2, ($urandom % 3) != 0);
    end
    step(1'b0, '0, 1'b0, 1'b1);
    step(1'b0, '0, 1'b0, 1'b1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule